// File: doc/BRIEF.md
# Multi-Context Time-Multiplexed Lookup Cell

This block is one programmable logic cell built around a 4-input lookup table. Every one of the 16 table entries keeps eight configuration bits instead of one. Each bit belongs to one context. A free-running counter steps the active context on every fast clock cycle. One physical cell therefore computes a different logic function on each cycle, with no reprogramming between them.

The user-visible rate is the fast clock divided by eight. One full pass over the contexts is one user cycle, and the cell marks its start with a single-cycle pulse. Table contents and per-context feedback options are loaded through a slow, bit-at-a-time configuration port. That port works only in configuration mode, and the sequencer rests at context 0 while it is open.

The output is registered. A context can be set to take the registered output, which holds the result of the previous context in the same pass, in place of logic input 0. A computation can therefore be chained across contexts inside a single cell.

Top module: `mctx_lut`

## Requirements
- R1: The table holds 16 entries of 8 bits. On each run-mode clock edge the output `q` takes bit `ctx` of entry `lut_in`, where `lut_in[0]` is address bit 0 and `ctx` is the context active at that edge.
- R2: With `cfg_mode` low, the context advances by one on every edge in the order 0,1,…,7,0. No data or configuration input skips, holds or reorders it.
- R3: When `lut_in` and the context change on the same cycle, the next output uses the new address and the new context together.
- R4: A write (`cfg_we`=1) is accepted only while `cfg_mode` is high. With `cfg_sel_fb`=0 it stores `cfg_data` into bit `cfg_ctx` of entry `cfg_addr`. With `cfg_sel_fb`=1 it stores `cfg_data` as the feedback flag of context `cfg_ctx`. A write raised while `cfg_mode` is low changes nothing.
- R5: While `cfg_mode` is high, the context is held at 0, `q` keeps its value and `wrap` is 0.
- R6: A synchronous `rst` sets the context to 0, `q` to 0 and `wrap` to 0. Table contents and feedback flags are left as they were.
- R7: `wrap` is 1 for exactly the one cycle after the context moves from 7 to 0 in run mode, and 0 otherwise.
- R8: For a context whose feedback flag is 1, the table address is `{lut_in[3:1], q}`. Here `q` is the result of the preceding context.
- R9: A full pass takes 8 fast cycles, so `wrap` repeats every 8 cycles in uninterrupted run mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | Configuration mode; freezes sequencer at context 0 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel_fb | input | 1 | 1 writes a feedback flag, 0 writes a table bit |
| cfg_addr | input | 4 | Table entry to write |
| cfg_ctx | input | 3 | Context of the bit or flag to write |
| cfg_data | input | 1 | Value to write |
| lut_in | input | 4 | Logic inputs (table address) |
| q | output | 1 | Registered cell output |
| ctx | output | 3 | Currently active context |
| wrap | output | 1 | Start-of-pass pulse |

## Verification
The assertions assume that `rst` is high from time zero until at least one clock edge has occurred. They also assume that every input is stable around the rising edge. The bench holds reset over the first edges and changes inputs only on falling edges. The bench also opens and closes configuration mode at arbitrary points in a pass, and it raises stray write strobes during run mode. This shows that the sequencer is affected only by `cfg_mode` and `rst`.

// File: rtl/mctx_lut.sv
module mctx_lut #(
  parameter int N_IN  = 4,
  parameter int N_CTX = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_mode,
  input  logic                     cfg_we,
  input  logic                     cfg_sel_fb,
  input  logic [N_IN-1:0]          cfg_addr,
  input  logic [$clog2(N_CTX)-1:0] cfg_ctx,
  input  logic                     cfg_data,
  input  logic [N_IN-1:0]          lut_in,
  output logic                     q,
  output logic [$clog2(N_CTX)-1:0] ctx,
  output logic                     wrap
);
  localparam int CW      = $clog2(N_CTX);
  localparam int DEPTH   = 1 << N_IN;
  localparam logic [CW-1:0] LAST = CW'(N_CTX - 1);

  logic [N_CTX-1:0] tbl [DEPTH];
  logic [N_CTX-1:0] fb_en;
  logic [N_IN-1:0]  addr_eff;
  logic             wr;

  assign wr       = cfg_mode && cfg_we;
  assign addr_eff = fb_en[ctx] ? {lut_in[N_IN-1:1], q} : lut_in;

  always_ff @(posedge clk) begin
    if (wr && !cfg_sel_fb) tbl[cfg_addr][cfg_ctx] <= cfg_data;
    if (wr && cfg_sel_fb)  fb_en[cfg_ctx] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx  <= '0;
      q    <= 1'b0;
      wrap <= 1'b0;
    end else if (cfg_mode) begin
      ctx  <= '0;
      wrap <= 1'b0;
    end else begin
      q    <= tbl[addr_eff][ctx];
      wrap <= (ctx == LAST);
      ctx  <= (ctx == LAST) ? '0 : ctx + CW'(1);
    end
  end
endmodule

// File: rtl/mctx_lut_chk.sv
module mctx_lut_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_mode,
  input logic [CW-1:0] ctx,
  input logic          q,
  input logic          wrap
);
  localparam logic [CW-1:0] LAST = '1;

  a_r2_ctx_steps: assert property (@(posedge clk) disable iff (rst)
    !cfg_mode |=> ctx == CW'($past(ctx) + CW'(1)));

  a_r5_ctx_frozen: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> (ctx == '0 && !wrap));

  a_r5_q_held: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> $stable(q));

  a_r6_reset_state: assert property (@(posedge clk)
    rst |=> (ctx == '0 && !q && !wrap));

  a_r7_wrap_origin: assert property (@(posedge clk) disable iff (rst)
    $rose(wrap) |-> (ctx == '0 && $past(ctx) == LAST && !$past(cfg_mode)));

  a_r7_wrap_single: assert property (@(posedge clk) disable iff (rst)
    wrap |=> !wrap);
endmodule

bind mctx_lut mctx_lut_chk #(.CW($clog2(N_CTX))) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .ctx(ctx), .q(q), .wrap(wrap)
);

// File: tb/mctx_lut_tb.sv
module mctx_lut_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_mode = 1'b0, cfg_we = 1'b0, cfg_sel_fb = 1'b0, cfg_data = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [2:0] cfg_ctx = '0;
  logic [3:0] lut_in = '0;
  logic       q, wrap;
  logic [2:0] ctx;

  int n_cmp = 0, n_bad = 0;
  string tag = "R6";

  logic [7:0] m_tbl [16];
  logic [7:0] m_fb = '0;
  int         m_ctx = 0;
  logic       m_q = 1'b0, m_wrap = 1'b0;
  int         since_wrap = 0;

  mctx_lut u_dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_we(cfg_we),
    .cfg_sel_fb(cfg_sel_fb), .cfg_addr(cfg_addr), .cfg_ctx(cfg_ctx),
    .cfg_data(cfg_data), .lut_in(lut_in), .q(q), .ctx(ctx), .wrap(wrap)
  );

  always #2.5 clk = ~clk;

  function automatic logic [15:0] fn(input int c);
    case (c)
      0: return 16'h8000;
      1: return 16'hFFFE;
      2: return 16'h6666;
      3: return 16'h6996;
      4: return 16'h7FFF;
      5: return 16'h6996;
      6: return 16'hF0F0;
      default: return 16'h1E5A;
    endcase
  endfunction

  always @(posedge clk) begin
    int a;
    if (cfg_mode && cfg_we) begin
      if (cfg_sel_fb) m_fb[cfg_ctx] = cfg_data;
      else            m_tbl[cfg_addr][cfg_ctx] = cfg_data;
    end
    if (rst) begin
      m_ctx = 0; m_q = 1'b0; m_wrap = 1'b0;
    end else if (cfg_mode) begin
      m_ctx = 0; m_wrap = 1'b0;
    end else begin
      a = m_fb[m_ctx] ? {lut_in[3:1], m_q} : lut_in;
      m_q    = m_tbl[a][m_ctx];
      m_wrap = (m_ctx == 7);
      m_ctx  = (m_ctx + 1) % 8;
    end
    #1;
    n_cmp++;
    if (q !== m_q || ctx !== 3'(m_ctx) || wrap !== m_wrap) begin
      n_bad++;
      $display("FAIL %s: q/ctx/wrap actual %b/%0d/%b expected %b/%0d/%b",
               tag, q, ctx, wrap, m_q, m_ctx, m_wrap);
    end
    if (tag == "R9" && wrap) begin
      n_cmp++;
      if (since_wrap != 8) begin
        n_bad++;
        $display("FAIL R9: pass length actual %0d expected 8", since_wrap);
      end
      since_wrap = 1;
    end else if (wrap) since_wrap = 1;
    else since_wrap++;
  end

  task automatic wr_bit(input int e, input int c, input logic d, input logic fb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel_fb = fb; cfg_addr = 4'(e); cfg_ctx = 3'(c); cfg_data = d;
    lut_in = 4'($urandom);
  endtask

  task automatic run(input int n, input logic stray);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lut_in = 4'($urandom);
      cfg_we = stray ? 1'($urandom) : 1'b0;
      cfg_sel_fb = 1'($urandom); cfg_data = 1'($urandom);
      cfg_addr = 4'($urandom); cfg_ctx = 3'($urandom);
    end
  endtask

  initial begin
    for (int e = 0; e < 16; e++) m_tbl[e] = '0;
    tag = "R6";
    repeat (3) @(negedge clk);
    // R4/R5: load all contexts in configuration mode
    @(negedge clk);
    rst = 1'b0; cfg_mode = 1'b1;
    tag = "R4";
    for (int c = 0; c < 8; c++)
      for (int e = 0; e < 16; e++) wr_bit(e, c, fn(c)[e], 1'b0);
    for (int c = 0; c < 8; c++) wr_bit(0, c, (c == 5), 1'b1);
    @(negedge clk); cfg_we = 1'b0; cfg_mode = 1'b0;
    tag = "R1 R3 R8";
    run(400, 1'b0);
    tag = "R4";
    run(400, 1'b1);
    tag = "R9";
    run(160, 1'b0);
    // R5: enter configuration mode mid-pass, replace context 2
    tag = "R5";
    run(3, 1'b0);
    @(negedge clk); cfg_mode = 1'b1; cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    for (int e = 0; e < 16; e++) wr_bit(e, 2, 16'h9999 >> e, 1'b0);
    wr_bit(0, 3, 1'b1, 1'b1);
    @(negedge clk); cfg_we = 1'b0; cfg_mode = 1'b0;
    tag = "R2 R7";
    run(300, 1'b1);
    // R6: reset mid-run keeps the table
    tag = "R6";
    run(5, 1'b0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run(200, 1'b0);
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule